// File: doc/BRIEF.md
# Sleep and Wake-Up Controller

This block sequences the low-power state of a small 8-bit processor core. When the core executes its sleep instruction, the block stops the core clock, clears the watchdog and updates two status bits. The watchdog keeps counting while the core sleeps. The block then waits for a wake event. It brings the clock back, pulses a resume strobe and, when the global interrupt enable was set, requests a branch to the interrupt vector one cycle later. That cycle lets the instruction prefetched after the sleep instruction complete first.

A sleep instruction issued while an enabled interrupt is already pending does nothing. An enabled interrupt that arrives after the strobe cycle lets sleep complete fully and then wakes the core at once. A parameter mask marks the interrupt sources that can run without the core clock. Only those sources can wake the core. The power-down and time-out bits show how the core came back. An external reset request is raised for the reset pin and for a watchdog timeout while the core is awake. The controller has no output that drives the reset pin.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After power-on reset, osc_en_o=1, pd_o=1 and to_o=1, and wdt_clr_o, rst_req_o, resume_o and vector_req_o are all 0.
- R2: A sleep strobe in the awake state with no pending interrupt (no bit with both irq_flag_i and irq_en_i set) causes the following at the next edge: osc_en_o=0, pd_o=0, to_o=1, and a wdt_clr_o pulse of one cycle.
- R3: A sleep strobe while any interrupt has both its flag and enable set acts as a no-op. osc_en_o stays 1, pd_o and to_o do not change, and wdt_clr_o stays 0.
- R4: While asleep, an enabled flag on a source marked in WAKE_MASK does three things at the next edge: it raises osc_en_o, pulses wdt_clr_o and leaves pd_o=0 and to_o=1. resume_o pulses for one cycle at the edge after that, and this happens whatever the value of gie_i.
- R5: vector_req_o pulses for one cycle in the cycle after resume_o when gie_i was 1 at the interrupt wake. It stays 0 when gie_i was 0 and after a watchdog wake.
- R6: While asleep, flags that are not enabled, and sources whose WAKE_MASK bit is 0, leave osc_en_o at 0. With the default mask 8'h7F, source 7 cannot wake the core.
- R7: While asleep with wdt_en_i=1, a wdt_timeout_i wakes the core. It clears to_o, raises osc_en_o and pulses wdt_clr_o at the next edge, and resume_o follows one cycle later. With wdt_en_i=0 the timeout is ignored.
- R8: ext_rst_ni low in any state causes the following from the next edge on, for as long as the pin stays low: rst_req_o=1 and osc_en_o=1, and pd_o and to_o keep their values.
- R9: A watchdog timeout with wdt_en_i=1 while awake gives a one-cycle rst_req_o pulse at the next edge, with to_o=0 and pd_o=1.
- R10: resume_o and vector_req_o are single-cycle pulses. resume_o is only issued when osc_en_o was already 1 in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| sleep_exec_i | input | 1 | Strobe: sleep instruction executing |
| ext_rst_ni | input | 1 | External reset pin, active low, synchronized |
| wdt_en_i | input | 1 | Watchdog enabled |
| wdt_timeout_i | input | 1 | Watchdog timeout strobe |
| irq_flag_i | input | N_IRQ | Interrupt flags |
| irq_en_i | input | N_IRQ | Interrupt enables (own and peripheral combined) |
| gie_i | input | 1 | Global interrupt enable |
| osc_en_o | output | 1 | Oscillator / core clock enable |
| wdt_clr_o | output | 1 | Watchdog clear pulse |
| pd_o | output | 1 | Power-down status bit |
| to_o | output | 1 | Time-out status bit |
| rst_req_o | output | 1 | Device reset request |
| resume_o | output | 1 | Resume execution pulse |
| vector_req_o | output | 1 | Branch to interrupt vector pulse |

## Verification
A sequencer stuck in the wrong state shows on osc_en_o within one edge. Either the clock fails to stop on a strobe or it stays off when a wake condition is present. A lost branch flag shows as a missing or spurious vector_req_o exactly two edges after the wake event. A wrong status-bit update is visible on pd_o and to_o at the edge that follows the sleep strobe, the watchdog timeout or the wake.

// File: rtl/sleep_wake_pkg.sv
package sleep_wake_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE  = 2'd0,
    ST_ASLEEP = 2'd1,
    ST_WARM   = 2'd2,
    ST_BRANCH = 2'd3
  } sw_state_e;
endpackage

// File: rtl/swc_irq_gate.sv
module swc_irq_gate #(
  parameter int unsigned N_IRQ     = 8,
  parameter logic [N_IRQ-1:0] WAKE_MASK = '1
) (
  input  logic [N_IRQ-1:0] irq_flag_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  output logic             pending_o,
  output logic             wake_o
);
  logic [N_IRQ-1:0] live;
  logic [N_IRQ-1:0] wakeable;

  for (genvar g = 0; g < N_IRQ; g++) begin : g_src
    assign live[g] = irq_flag_i[g] & irq_en_i[g];
    if (WAKE_MASK[g]) begin : g_async
      assign wakeable[g] = live[g];
    end else begin : g_clocked
      assign wakeable[g] = 1'b0;
    end
  end

  assign pending_o = |live;
  assign wake_o    = |wakeable;
endmodule

// File: rtl/swc_status.sv
module swc_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enter_i,
  input  logic wdt_wake_i,
  input  logic wdt_rst_i,
  output logic pd_o,
  output logic to_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_o <= 1'b1;
      to_o <= 1'b1;
    end else if (wdt_rst_i) begin
      pd_o <= 1'b1;
      to_o <= 1'b0;
    end else if (enter_i) begin
      pd_o <= 1'b0;
      to_o <= 1'b1;
    end else if (wdt_wake_i) begin
      to_o <= 1'b0;
    end
  end
endmodule

// File: rtl/swc_fsm.sv
module swc_fsm
  import sleep_wake_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sleep_exec_i,
  input  logic      ext_rst_ni,
  input  logic      wdt_en_i,
  input  logic      wdt_timeout_i,
  input  logic      pending_i,
  input  logic      wake_i,
  input  logic      gie_i,
  output logic      enter_o,
  output logic      wdt_wake_o,
  output logic      wdt_rst_o,
  output logic      osc_en_o,
  output logic      wdt_clr_o,
  output logic      rst_req_o,
  output logic      resume_o,
  output logic      vector_req_o
);
  sw_state_e state_q, state_d;
  logic      branch_q;
  logic      ext_hit, wdt_hit, irq_wake;

  always_comb begin
    ext_hit    = !ext_rst_ni;
    wdt_hit    = wdt_en_i & wdt_timeout_i;
    enter_o    = (state_q == ST_AWAKE) & sleep_exec_i & !pending_i & !ext_hit & !wdt_hit;
    wdt_rst_o  = (state_q != ST_ASLEEP) & wdt_hit & !ext_hit;
    wdt_wake_o = (state_q == ST_ASLEEP) & wdt_hit & !ext_hit;
    irq_wake   = (state_q == ST_ASLEEP) & wake_i & !wdt_hit & !ext_hit;
  end

  always_comb begin
    state_d = state_q;
    if (ext_hit) begin
      state_d = ST_AWAKE;
    end else begin
      unique case (state_q)
        ST_AWAKE:  if (enter_o) state_d = ST_ASLEEP;
        ST_ASLEEP: if (wdt_wake_o || irq_wake) state_d = ST_WARM;
        ST_WARM:   state_d = branch_q ? ST_BRANCH : ST_AWAKE;
        ST_BRANCH: state_d = ST_AWAKE;
        default:   state_d = ST_AWAKE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_AWAKE;
      branch_q     <= 1'b0;
      osc_en_o     <= 1'b1;
      wdt_clr_o    <= 1'b0;
      rst_req_o    <= 1'b0;
      resume_o     <= 1'b0;
      vector_req_o <= 1'b0;
    end else begin
      state_q      <= state_d;
      wdt_clr_o    <= enter_o | wdt_wake_o | irq_wake;
      rst_req_o    <= ext_hit | wdt_rst_o;
      resume_o     <= (state_q == ST_WARM) & !ext_hit;
      vector_req_o <= (state_q == ST_BRANCH) & !ext_hit;
      if (ext_hit || wdt_wake_o) branch_q <= 1'b0;
      else if (irq_wake)         branch_q <= gie_i;
      else if (state_q == ST_BRANCH) branch_q <= 1'b0;
      if (ext_hit || wdt_wake_o || irq_wake) osc_en_o <= 1'b1;
      else if (enter_o)                     osc_en_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl #(
  parameter int unsigned      N_IRQ     = 8,
  parameter logic [N_IRQ-1:0] WAKE_MASK = 8'h7F
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_exec_i,
  input  logic             ext_rst_ni,
  input  logic             wdt_en_i,
  input  logic             wdt_timeout_i,
  input  logic [N_IRQ-1:0] irq_flag_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic             gie_i,
  output logic             osc_en_o,
  output logic             wdt_clr_o,
  output logic             pd_o,
  output logic             to_o,
  output logic             rst_req_o,
  output logic             resume_o,
  output logic             vector_req_o
);
  logic pending, wake, enter, wdt_wake, wdt_rst;

  swc_irq_gate #(.N_IRQ(N_IRQ), .WAKE_MASK(WAKE_MASK)) u_gate (
    .irq_flag_i (irq_flag_i),
    .irq_en_i   (irq_en_i),
    .pending_o  (pending),
    .wake_o     (wake)
  );

  swc_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sleep_exec_i  (sleep_exec_i),
    .ext_rst_ni    (ext_rst_ni),
    .wdt_en_i      (wdt_en_i),
    .wdt_timeout_i (wdt_timeout_i),
    .pending_i     (pending),
    .wake_i        (wake),
    .gie_i         (gie_i),
    .enter_o       (enter),
    .wdt_wake_o    (wdt_wake),
    .wdt_rst_o     (wdt_rst),
    .osc_en_o      (osc_en_o),
    .wdt_clr_o     (wdt_clr_o),
    .rst_req_o     (rst_req_o),
    .resume_o      (resume_o),
    .vector_req_o  (vector_req_o)
  );

  swc_status u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enter_i    (enter),
    .wdt_wake_i (wdt_wake),
    .wdt_rst_i  (wdt_rst),
    .pd_o       (pd_o),
    .to_o       (to_o)
  );
endmodule

// File: rtl/sleep_wake_ctrl_chk.sv
module sleep_wake_ctrl_chk #(
  parameter int unsigned      N_IRQ     = 8,
  parameter logic [N_IRQ-1:0] WAKE_MASK = 8'h7F
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sleep_exec_i,
  input logic             ext_rst_ni,
  input logic             wdt_en_i,
  input logic             wdt_timeout_i,
  input logic [N_IRQ-1:0] irq_flag_i,
  input logic [N_IRQ-1:0] irq_en_i,
  input logic             osc_en_o,
  input logic             wdt_clr_o,
  input logic             pd_o,
  input logic             to_o,
  input logic             rst_req_o,
  input logic             resume_o,
  input logic             vector_req_o
);
  p_sleep_enter_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(osc_en_o) |-> (!pd_o && to_o && wdt_clr_o));

  p_nop_sleep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_en_o && sleep_exec_i && |(irq_flag_i & irq_en_i) && ext_rst_ni && !wdt_timeout_i)
    |=> (osc_en_o && $stable(pd_o) && $stable(to_o)));

  p_vector_after_resume_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vector_req_o |-> $past(resume_o));

  p_ignore_unmasked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osc_en_o && ext_rst_ni && !(wdt_en_i && wdt_timeout_i)
     && !(|(irq_flag_i & irq_en_i & WAKE_MASK))) |=> !osc_en_o);

  p_ext_reset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_rst_ni |=> (rst_req_o && osc_en_o));

  p_resume_clock_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |-> ($past(osc_en_o) && osc_en_o));

  p_resume_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |=> !resume_o);

  p_vector_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vector_req_o |=> !vector_req_o);
endmodule

bind sleep_wake_ctrl sleep_wake_ctrl_chk #(.N_IRQ(N_IRQ), .WAKE_MASK(WAKE_MASK)) u_chk (.*);

// File: tb/sleep_wake_ctrl_tb_top.sv
module sleep_wake_ctrl_tb_top;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sleep_exec = 1'b0, ext_rst_n = 1'b1, wdt_en = 1'b0, wdt_to = 1'b0, gie = 1'b0;
  logic [N-1:0] flag = '0, en = '0;
  logic         osc_en, wdt_clr, pd, to, rst_req, resume, vec;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  sleep_wake_ctrl #(.N_IRQ(N), .WAKE_MASK(8'h7F)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sleep_exec_i(sleep_exec), .ext_rst_ni(ext_rst_n),
    .wdt_en_i(wdt_en), .wdt_timeout_i(wdt_to), .irq_flag_i(flag), .irq_en_i(en),
    .gie_i(gie), .osc_en_o(osc_en), .wdt_clr_o(wdt_clr), .pd_o(pd), .to_o(to),
    .rst_req_o(rst_req), .resume_o(resume), .vector_req_o(vec)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic enter_sleep();
    sleep_exec = 1'b1;
    step();
    sleep_exec = 1'b0;
    chk("R2", "osc_en after strobe", osc_en, 1'b0);
    chk("R2", "pd after strobe", pd, 1'b0);
    chk("R2", "to after strobe", to, 1'b1);
    chk("R2", "wdt_clr pulse", wdt_clr, 1'b1);
    step();
    chk("R2", "wdt_clr one cycle", wdt_clr, 1'b0);
  endtask

  task automatic t_reset_r1();
    chk("R1", "osc_en", osc_en, 1'b1);
    chk("R1", "pd", pd, 1'b1);
    chk("R1", "to", to, 1'b1);
    chk("R1", "pulses", wdt_clr | rst_req | resume | vec, 1'b0);
  endtask

  task automatic t_nop_r3();
    flag = 8'h01; en = 8'h01;
    sleep_exec = 1'b1;
    step();
    sleep_exec = 1'b0;
    chk("R3", "osc_en stays", osc_en, 1'b1);
    chk("R3", "pd unchanged", pd, 1'b1);
    chk("R3", "to unchanged", to, 1'b1);
    chk("R3", "no wdt_clr", wdt_clr, 1'b0);
    flag = '0; en = '0;
    step();
  endtask

  task automatic t_irq_wake(input logic g);
    enter_sleep();
    gie = g;
    en = 8'h04; flag = 8'h04;
    step();
    flag = '0; gie = 1'b0;
    chk("R4", "osc_en raised", osc_en, 1'b1);
    chk("R4", "wdt_clr on wake", wdt_clr, 1'b1);
    chk("R4", "no early resume", resume, 1'b0);
    chk("R4", "pd kept", pd, 1'b0);
    chk("R4", "to kept", to, 1'b1);
    step();
    chk("R4", "resume pulse", resume, 1'b1);
    chk("R5", "no vector with resume", vec, 1'b0);
    step();
    chk("R10", "resume one cycle", resume, 1'b0);
    chk("R5", "vector follows gie", vec, g);
    step();
    chk("R10", "vector one cycle", vec, 1'b0);
    en = '0;
  endtask

  task automatic t_ignore_r6();
    enter_sleep();
    flag = 8'h81; en = 8'h80;
    repeat (3) step();
    chk("R6", "unmasked/unenabled ignored", osc_en, 1'b0);
    chk("R6", "no resume", resume, 1'b0);
    flag = '0; en = '0;
  endtask

  task automatic t_wdt_wake_r7();
    wdt_en = 1'b0; wdt_to = 1'b1;
    step();
    wdt_to = 1'b0;
    chk("R7", "disabled timeout ignored", osc_en, 1'b0);
    chk("R7", "to kept when disabled", to, 1'b1);
    wdt_en = 1'b1; wdt_to = 1'b1; gie = 1'b1;
    step();
    wdt_to = 1'b0;
    chk("R7", "osc_en on wdt wake", osc_en, 1'b1);
    chk("R7", "to cleared", to, 1'b0);
    chk("R7", "wdt_clr on wake", wdt_clr, 1'b1);
    chk("R7", "no reset on wake", rst_req, 1'b0);
    step();
    chk("R7", "resume", resume, 1'b1);
    step();
    chk("R5", "no vector after wdt wake", vec, 1'b0);
    gie = 1'b0; wdt_en = 1'b0;
  endtask

  task automatic t_ext_reset_r8();
    enter_sleep();
    ext_rst_n = 1'b0;
    step();
    chk("R8", "rst_req", rst_req, 1'b1);
    chk("R8", "osc_en", osc_en, 1'b1);
    chk("R8", "pd kept", pd, 1'b0);
    chk("R8", "to kept", to, 1'b1);
    step();
    chk("R8", "rst_req held", rst_req, 1'b1);
    ext_rst_n = 1'b1;
    step();
    chk("R8", "rst_req released", rst_req, 1'b0);
  endtask

  task automatic t_wdt_reset_r9();
    wdt_en = 1'b1; wdt_to = 1'b1;
    step();
    wdt_to = 1'b0;
    chk("R9", "rst_req pulse", rst_req, 1'b1);
    chk("R9", "to cleared", to, 1'b0);
    chk("R9", "pd set", pd, 1'b1);
    chk("R9", "osc_en stays", osc_en, 1'b1);
    step();
    chk("R9", "rst_req one cycle", rst_req, 1'b0);
    wdt_en = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    t_reset_r1();
    rst_n = 1'b1;
    step();
    t_reset_r1();
    t_nop_r3();
    t_irq_wake(1'b0);
    t_irq_wake(1'b1);
    t_ignore_r6();
    t_wdt_wake_r7();
    t_ext_reset_r8();
    t_wdt_reset_r9();
    step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule